// File: doc/BRIEF.md
# Host Register Interface for a Network Adapter

This block is the host-visible register window of a network adapter. The host reaches it through a synchronous strobe bus. Each access carries a 4-bit byte offset, a write flag and a 16-bit data word. Through this window the host can do four things: reach adapter memory through a data port, set a 32-bit memory pointer, send command bits to the adapter core, and read back core status.

A separate select pin opens an extended bank. That bank holds an adapter control word, an alias of the low pointer word, the high pointer word and a DMA length. The control word keeps the core in reset while its reset bit is high. The halt and interrupt-enable bits are guarded: they can change only while reset is already asserted.

The core raises interrupts with a 4-bit reason code. The host clears them by writing the command location with bit 7 low. A combinational lane reorder presents 32-bit DMA items in host byte order.

Top module: `host_sif_regs`

## Requirements
- R1: After reset the control word reads 0x0080 and `core_reset_o` is 1. The pointer is 0, the DMA length is 0, `sys_irq_o` is 0 and `cmd_pulse_o` is 0.
- R2: A write to offset 0x6 drives `cmd_pulse_o` with write data bits 15:8 during the following cycle only. In all other cycles `cmd_pulse_o` is 0.
- R3: A write to offset 0x6 with data bit 7 equal to 0 clears the pending interrupt. With bit 7 equal to 1, the pending interrupt is left as it is.
- R4: `core_irq_i` sets the pending interrupt only when control bit 3 (interrupt enable) is 1. If a set and a clear fall in the same cycle, the set wins. `sys_irq_o` shows the pending flag.
- R5: A read of offset 0x6 returns the status word, laid out as follows:
  - bits 15:8 are 0;
  - bit 7 is the pending interrupt;
  - bit 6 is `core_init_i`;
  - bit 5 is `core_test_i`;
  - bit 4 is `core_err_i`;
  - bits 3:0 are the code captured on the last `core_irq_i`.
- R6: Control bit 7 drives `core_reset_o` directly, and it changes only through a control write.
- R7: A control write updates bits 6 (halt, driven on `core_halt_o`) and 3 (interrupt enable) only if the stored bit 7 was 1 before that write. All other control bits always take the written value.
- R8: The pointer auto-increments on data port accesses:
  - a word access at offset 0x2 adds 2 to the 32-bit pointer;
  - a byte access at offset 0x3 adds 1;
  - a carry from the low word propagates into the high word;
  - an access at offset 0x0 leaves the pointer unchanged.
- R9: With `ext_sel_i` = 1, offsets 0x8, 0xA, 0xC and 0xE reach, in that order, the control word, the low pointer word (the same register as offset 0x4), the high pointer word and the DMA length. With `ext_sel_i` = 0, those offsets read 0 and writes to them are ignored. Odd offsets other than 0x3 also read 0.
- R10: Offsets 0x0, 0x2 and 0x3 issue `mem_req_o` at the current pointer.
  - Word accesses use byte enables 2'b11.
  - A byte access uses 2'b10 (bits 15:8) at an even pointer and 2'b01 at an odd one. Its write data appears on both lanes, and its read returns the selected lane in bits 7:0.
- R11: `dma_swap_o` is `dma_raw_i` with its bytes in reverse order. This is the same as swapping the bytes within each 16-bit word and then swapping the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_sel_i | input | 1 | Extended bank select |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational during the access |
| cmd_pulse_o | output | 8 | One-cycle command bits toward the core |
| sys_irq_o | output | 1 | Pending system interrupt |
| core_reset_o | output | 1 | Core held in reset |
| core_halt_o | output | 1 | Core processor halted |
| core_irq_i | input | 1 | Core interrupt strobe |
| core_code_i | input | 4 | Interrupt or error code |
| core_init_i | input | 1 | Core in initialize state |
| core_test_i | input | 1 | Core self-test running |
| core_err_i | input | 1 | Core unrecoverable error |
| mem_req_o | output | 1 | Memory access through a data port |
| mem_we_o | output | 1 | Memory write |
| mem_be_o | output | 2 | Memory byte enables |
| mem_addr_o | output | 32 | Memory pointer |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, combinational |
| dma_len_o | output | 16 | DMA length register |
| dma_raw_i | input | 32 | DMA item in adapter order |
| dma_swap_o | output | 32 | DMA item in host order |

## Verification
The assertions assume the following about the inputs:
- the host holds `req_i` low while reset is asserted;
- the host presents at most one access per cycle, with `addr_i` and `we_i` stable across the sampling edge.

The stimulus keeps within these limits as follows:
- it drives every access on the falling edge;
- it drops the strobe right after the rising edge that commits the access;
- it raises `core_irq_i` for a single cycle at a time.

It also runs the pointer across the 16-bit boundary, and it makes the interrupt set and clear collide in one cycle.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFF_W  = 4;

  localparam logic [OFF_W-1:0] OFF_DATA   = 4'h0;
  localparam logic [OFF_W-1:0] OFF_DINC   = 4'h2;
  localparam logic [OFF_W-1:0] OFF_DINC_B = 4'h3;
  localparam logic [OFF_W-1:0] OFF_PTR    = 4'h4;
  localparam logic [OFF_W-1:0] OFF_CMD    = 4'h6;
  localparam logic [OFF_W-1:0] OFF_CTL    = 4'h8;
  localparam logic [OFF_W-1:0] OFF_PTR_X  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_PTR_HI = 4'hC;
  localparam logic [OFF_W-1:0] OFF_DLEN   = 4'hE;

  localparam int unsigned CTL_RST_BIT = 7;
  localparam int unsigned CTL_HLT_BIT = 6;
  localparam int unsigned CTL_IEN_BIT = 3;
  localparam int unsigned CMD_KEEP_BIT = 7;

  localparam logic [WORD_W-1:0] CTL_RESET_VAL = 16'h0080;
endpackage

// File: rtl/sif_ptr.sv
module sif_ptr
  import sif_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_lo_i,
  input  logic           wr_hi_i,
  input  logic [W-1:0]   wdata_i,
  input  logic           inc_i,
  input  logic           inc_byte_i,
  output logic [2*W-1:0] ptr_o
);
  localparam logic [2*W-1:0] STEP_WORD = 2;
  localparam logic [2*W-1:0] STEP_BYTE = 1;

  logic [W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i;
    end else if (inc_i) begin
      {hi_q, lo_q} <= {hi_q, lo_q} + (inc_byte_i ? STEP_BYTE : STEP_WORD);
    end
  end

  assign ptr_o = {hi_q, lo_q};
endmodule

// File: rtl/sif_ctl.sv
module sif_ctl
  import sif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] ctl_o
);
  logic [WORD_W-1:0] ctl_q, ctl_d;

  // guarded bits keep their value unless reset was already held
  always_comb begin
    ctl_d = wdata_i;
    if (!ctl_q[CTL_RST_BIT]) begin
      ctl_d[CTL_HLT_BIT] = ctl_q[CTL_HLT_BIT];
      ctl_d[CTL_IEN_BIT] = ctl_q[CTL_IEN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= CTL_RESET_VAL;
    else if (wr_i) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/sif_irq.sv
module sif_irq #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_irq_i,
  input  logic [CODE_W-1:0] core_code_i,
  input  logic              ien_i,
  input  logic              clr_i,
  output logic              pend_o,
  output logic [CODE_W-1:0] code_o
);
  logic              pend_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (core_irq_i && ien_i) pend_q <= 1'b1;
      else if (clr_i)          pend_q <= 1'b0;
      if (core_irq_i) code_q <= core_code_i;
    end
  end

  assign pend_o = pend_q;
  assign code_o = code_q;
endmodule

// File: rtl/host_sif_regs.sv
module host_sif_regs
  import sif_pkg::*;
#(
  parameter int unsigned DMA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_sel_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [OFF_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [BYTE_W-1:0]   cmd_pulse_o,
  output logic                sys_irq_o,
  output logic                core_reset_o,
  output logic                core_halt_o,
  input  logic                core_irq_i,
  input  logic [3:0]          core_code_i,
  input  logic                core_init_i,
  input  logic                core_test_i,
  input  logic                core_err_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [1:0]          mem_be_o,
  output logic [2*WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic [WORD_W-1:0]   dma_len_o,
  input  logic [DMA_W-1:0]    dma_raw_i,
  output logic [DMA_W-1:0]    dma_swap_o
);
  localparam int unsigned NBYTES = DMA_W / BYTE_W;

  logic ext_ok;
  logic s_data, s_dinc, s_dincb, s_ptr, s_cmd, s_ctl, s_ptrx, s_ptrhi, s_dlen;
  logic [2*WORD_W-1:0] ptr;
  logic [WORD_W-1:0]   ctl;
  logic [3:0]          irq_code;
  logic                irq_pend;
  logic [WORD_W-1:0]   status;
  logic [WORD_W-1:0]   dlen_q;
  logic [BYTE_W-1:0]   pulse_q;

  assign ext_ok  = req_i && ext_sel_i;
  assign s_data  = req_i && (addr_i == OFF_DATA);
  assign s_dinc  = req_i && (addr_i == OFF_DINC);
  assign s_dincb = req_i && (addr_i == OFF_DINC_B);
  assign s_ptr   = req_i && (addr_i == OFF_PTR);
  assign s_cmd   = req_i && (addr_i == OFF_CMD);
  assign s_ctl   = ext_ok && (addr_i == OFF_CTL);
  assign s_ptrx  = ext_ok && (addr_i == OFF_PTR_X);
  assign s_ptrhi = ext_ok && (addr_i == OFF_PTR_HI);
  assign s_dlen  = ext_ok && (addr_i == OFF_DLEN);

  sif_ptr #(.W(WORD_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lo_i    (we_i && (s_ptr || s_ptrx)),
    .wr_hi_i    (we_i && s_ptrhi),
    .wdata_i    (wdata_i),
    .inc_i      (s_dinc || s_dincb),
    .inc_byte_i (s_dincb),
    .ptr_o      (ptr)
  );

  sif_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && s_ctl),
    .wdata_i (wdata_i),
    .ctl_o   (ctl)
  );

  sif_irq #(.CODE_W(4)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_irq_i  (core_irq_i),
    .core_code_i (core_code_i),
    .ien_i       (ctl[CTL_IEN_BIT]),
    .clr_i       (we_i && s_cmd && !wdata_i[CMD_KEEP_BIT]),
    .pend_o      (irq_pend),
    .code_o      (irq_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlen_q  <= '0;
      pulse_q <= '0;
    end else begin
      if (we_i && s_dlen) dlen_q <= wdata_i;
      pulse_q <= (we_i && s_cmd) ? wdata_i[WORD_W-1 -: BYTE_W] : '0;
    end
  end

  assign status = {{BYTE_W{1'b0}}, irq_pend, core_init_i, core_test_i, core_err_i, irq_code};

  // memory side of the data ports; even pointer selects the high lane
  assign mem_req_o   = s_data || s_dinc || s_dincb;
  assign mem_we_o    = mem_req_o && we_i;
  assign mem_addr_o  = ptr;
  assign mem_be_o    = s_dincb ? (ptr[0] ? 2'b01 : 2'b10) : 2'b11;
  assign mem_wdata_o = s_dincb ? {2{wdata_i[BYTE_W-1:0]}} : wdata_i;

  always_comb begin
    rdata_o = '0;
    if (s_data || s_dinc) rdata_o = mem_rdata_i;
    else if (s_dincb)     rdata_o = {{BYTE_W{1'b0}},
                                     ptr[0] ? mem_rdata_i[BYTE_W-1:0] : mem_rdata_i[WORD_W-1 -: BYTE_W]};
    else if (s_ptr || s_ptrx) rdata_o = ptr[WORD_W-1:0];
    else if (s_cmd)       rdata_o = status;
    else if (s_ctl)       rdata_o = ctl;
    else if (s_ptrhi)     rdata_o = ptr[2*WORD_W-1:WORD_W];
    else if (s_dlen)      rdata_o = dlen_q;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_swap
    assign dma_swap_o[i*BYTE_W +: BYTE_W] = dma_raw_i[(NBYTES-1-i)*BYTE_W +: BYTE_W];
  end

  assign cmd_pulse_o  = pulse_q;
  assign sys_irq_o    = irq_pend;
  assign core_reset_o = ctl[CTL_RST_BIT];
  assign core_halt_o  = ctl[CTL_HLT_BIT];
  assign dma_len_o    = dlen_q;
endmodule

// File: rtl/host_sif_regs_chk.sv
module host_sif_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ext_sel_i,
  input logic        req_i,
  input logic        we_i,
  input logic [3:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic [7:0]  cmd_pulse_o,
  input logic        sys_irq_o,
  input logic        core_irq_i,
  input logic        core_reset_o,
  input logic        core_halt_o,
  input logic [31:0] mem_addr_o
);
  logic cmd_wr, ctl_wr;
  assign cmd_wr = req_i && we_i && (addr_i == 4'h6);
  assign ctl_wr = req_i && we_i && ext_sel_i && (addr_i == 4'h8);

  assert_cmd_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> cmd_pulse_o == $past(wdata_i[15:8]));
  assert_cmd_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> cmd_pulse_o == 8'h00);
  assert_irq_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_irq_o) |-> $past(cmd_wr && !wdata_i[7]));
  assert_irq_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_irq_o) |-> $past(core_irq_i));
  assert_status_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 4'h6) |-> (rdata_o[15:8] == 8'h00 && rdata_o[7] == sys_irq_o));
  assert_reset_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctl_wr) |-> $stable(core_reset_o));
  assert_halt_guard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_halt_o) |-> $past(core_reset_o));
  assert_plain_port_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == 4'h0) |=> $stable(mem_addr_o));
  assert_word_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == 4'h2) |=> mem_addr_o == $past(mem_addr_o) + 32'd2);
endmodule

bind host_sif_regs host_sif_regs_chk u_chk (.*);

// File: tb/host_sif_regs_test.sv
`timescale 1ns/1ps
module host_sif_regs_test;
  localparam time CLK_P = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_sel = 1'b0, req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [7:0] cmd_pulse;
  logic sys_irq, core_reset, core_halt;
  logic core_irq = 1'b0, core_init = 1'b0, core_test = 1'b0, core_err = 1'b0;
  logic [3:0] core_code = '0;
  logic mem_req, mem_we;
  logic [1:0] mem_be;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, dma_len;
  logic [31:0] dma_raw = '0, dma_swap;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;
  assign mem_rdata = mem_addr[15:0] ^ 16'hA5A5;

  host_sif_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_sel_i(ext_sel), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cmd_pulse_o(cmd_pulse),
    .sys_irq_o(sys_irq), .core_reset_o(core_reset), .core_halt_o(core_halt),
    .core_irq_i(core_irq), .core_code_i(core_code), .core_init_i(core_init),
    .core_test_i(core_test), .core_err_i(core_err), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .dma_len_o(dma_len),
    .dma_raw_i(dma_raw), .dma_swap_o(dma_swap)
  );

  typedef struct packed {
    logic        ext;
    logic        wr;
    logic [3:0]  off;
    logic [15:0] wd;
    logic [15:0] exp;
    logic        chk;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,4'h8,16'h0000,16'h0080,1'b1,4'd1},  // R1 control reset value
    '{1'b0,1'b1,4'h4,16'h1234,16'h0000,1'b0,4'd8},
    '{1'b1,1'b1,4'hC,16'h00AB,16'h0000,1'b0,4'd9},
    '{1'b0,1'b0,4'h4,16'h0000,16'h1234,1'b1,4'd8},
    '{1'b1,1'b0,4'hA,16'h0000,16'h1234,1'b1,4'd9},  // R9 alias
    '{1'b1,1'b0,4'hC,16'h0000,16'h00AB,1'b1,4'd9},
    '{1'b0,1'b0,4'hC,16'h0000,16'h0000,1'b1,4'd9},  // R9 bank closed
    '{1'b0,1'b1,4'hE,16'h5555,16'h0000,1'b0,4'd9},
    '{1'b1,1'b0,4'hE,16'h0000,16'h0000,1'b1,4'd9},  // R9 write ignored
    '{1'b1,1'b1,4'hE,16'h0400,16'h0000,1'b0,4'd9},
    '{1'b1,1'b0,4'hE,16'h0000,16'h0400,1'b1,4'd9},
    '{1'b0,1'b1,4'h2,16'hBEEF,16'h0000,1'b0,4'd8},
    '{1'b0,1'b0,4'h4,16'h0000,16'h1236,1'b1,4'd8},  // R8 word step
    '{1'b0,1'b1,4'h3,16'h0077,16'h0000,1'b0,4'd8},
    '{1'b0,1'b0,4'h4,16'h0000,16'h1237,1'b1,4'd8},  // R8 byte step
    '{1'b0,1'b0,4'h0,16'h0000,16'hB792,1'b1,4'd10}, // R10 plain read
    '{1'b0,1'b0,4'h4,16'h0000,16'h1237,1'b1,4'd8},  // R8 plain port no step
    '{1'b1,1'b1,4'h8,16'h00C8,16'h0000,1'b0,4'd7},
    '{1'b1,1'b0,4'h8,16'h0000,16'h00C8,1'b1,4'd7},  // R7 accepted under reset
    '{1'b1,1'b1,4'h8,16'h0048,16'h0000,1'b0,4'd7},
    '{1'b1,1'b0,4'h8,16'h0000,16'h0048,1'b1,4'd7},
    '{1'b1,1'b1,4'h8,16'h0003,16'h0000,1'b0,4'd7},
    '{1'b1,1'b0,4'h8,16'h0000,16'h004B,1'b1,4'd7},  // R7 guarded bits held
    '{1'b0,1'b1,4'h4,16'hFFFF,16'h0000,1'b0,4'd8},
    '{1'b1,1'b1,4'hC,16'h0000,16'h0000,1'b0,4'd8},
    '{1'b0,1'b0,4'h2,16'h0000,16'h5A5A,1'b1,4'd10},
    '{1'b0,1'b0,4'h4,16'h0000,16'h0001,1'b1,4'd8},  // R8 carry low
    '{1'b1,1'b0,4'hC,16'h0000,16'h0001,1'b1,4'd8},  // R8 carry high
    '{1'b0,1'b0,4'h3,16'h0000,16'h00A4,1'b1,4'd10}, // R10 odd lane
    '{1'b0,1'b0,4'h3,16'h0000,16'h00A5,1'b1,4'd10}, // R10 even lane
    '{1'b0,1'b0,4'h4,16'h0000,16'h0003,1'b1,4'd8},
    '{1'b0,1'b0,4'h1,16'h0000,16'h0000,1'b1,4'd9}   // R9 unmapped odd
  };

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  logic [15:0] rd_v;
  logic m_req, m_we;
  logic [1:0] m_be;
  logic [15:0] m_wd;
  logic [31:0] m_ad;

  task automatic access(input logic e, input logic w, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    ext_sel = e; req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    rd_v = rdata; m_req = mem_req; m_we = mem_we; m_be = mem_be; m_wd = mem_wdata; m_ad = mem_addr;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic core_pulse(input logic [3:0] c);
    @(negedge clk);
    core_irq = 1'b1; core_code = c;
    @(posedge clk);
    #1 core_irq = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(1, core_reset, 1'b1);
    check(1, sys_irq, 1'b0);
    check(1, cmd_pulse, 8'h00);
    check(1, dma_len, 16'h0000);
    check(1, mem_addr, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].ext, VEC[i].wr, VEC[i].off, VEC[i].wd);
      if (VEC[i].chk) check(int'(VEC[i].rq), rd_v, VEC[i].exp);
    end

    check(9, dma_len, 16'h0400);          // R9
    check(6, core_reset, 1'b0);           // R6 released
    check(7, core_halt, 1'b1);            // R7

    // R2 command pulse lasts one cycle
    access(1'b0, 1'b1, 4'h6, 16'h9080);
    check(2, cmd_pulse, 8'h90);
    @(posedge clk); #1;
    check(2, cmd_pulse, 8'h00);

    // R4 / R5 interrupt with enable set
    core_pulse(4'hA);
    check(4, sys_irq, 1'b1);
    core_init = 1'b1;
    access(1'b0, 1'b0, 4'h6, 16'h0);
    check(5, rd_v, 16'h00CA);
    core_init = 1'b0;

    // R3 inverted clear sense
    access(1'b0, 1'b1, 4'h6, 16'h0080);
    check(3, sys_irq, 1'b1);
    access(1'b0, 1'b1, 4'h6, 16'h0000);
    check(3, sys_irq, 1'b0);

    // R6 / R7 entering reset keeps guarded bits
    access(1'b1, 1'b1, 4'h8, 16'h0080);
    check(6, core_reset, 1'b1);
    check(7, core_halt, 1'b1);
    access(1'b1, 1'b0, 4'h8, 16'h0);
    check(7, rd_v, 16'h00C8);
    access(1'b1, 1'b1, 4'h8, 16'h0080);
    check(7, core_halt, 1'b0);

    // R4 disabled interrupt, R5 code still captured
    core_pulse(4'hC);
    check(4, sys_irq, 1'b0);
    access(1'b0, 1'b0, 4'h6, 16'h0);
    check(5, rd_v, 16'h000C);

    // R4 set beats clear in the same cycle
    access(1'b1, 1'b1, 4'h8, 16'h0088);
    @(negedge clk);
    core_irq = 1'b1; core_code = 4'h4;
    ext_sel = 1'b0; req = 1'b1; we = 1'b1; addr = 4'h6; wdata = 16'h0000;
    @(posedge clk);
    #1 core_irq = 1'b0; req = 1'b0; we = 1'b0;
    check(4, sys_irq, 1'b1);

    // R10 memory side of writes
    access(1'b0, 1'b1, 4'h4, 16'h0010);
    access(1'b0, 1'b1, 4'h3, 16'h005A);
    check(10, {m_req, m_we, m_be}, {1'b1, 1'b1, 2'b10});
    check(10, m_wd, 16'h5A5A);
    access(1'b0, 1'b1, 4'h0, 16'h1357);
    check(10, {m_req, m_we, m_be}, {1'b1, 1'b1, 2'b11});
    check(10, m_wd, 16'h1357);
    check(10, m_ad, 32'h0001_0011);

    // R11 lane reorder
    @(negedge clk);
    dma_raw = 32'h1122_3344; #1;
    check(11, dma_swap, 32'h4433_2211);
    dma_raw = 32'hA1B2_C3D4; #1;
    check(11, dma_swap, 32'hD4C3_B2A1);

    summary();
  end
endmodule